// File: doc/BRIEF.md
# Address-Triggered Load/Store Register File

This block holds the operational registers of a 60-bit word machine in three banks of eight: address registers, data registers and index registers. There are no load or store operations. Memory traffic is a side effect of writing an address register, and the register number picks the direction. Writing address registers 1 through 5 fetches the word at the new address into the data register with the same number. Writing address registers 6 or 7 sends the data register with the same number to the new address. Writing address register 0 changes only that register.

An address register is written through a set-address operation. The operation adds one address register to one index register and places the 18-bit sum in a target address register. The sum uses register values from before the write, so a register may be its own source.

The memory side is a single-outstanding request port that holds its request until an acknowledge arrives. While an access is outstanding, the block raises `busy` and ignores further set-address operations. A separate direct write port loads the data and index banks, and a read port exposes every register.

Top module: `trig_regfile`

## Requirements
- R1: Synchronous active-high reset clears every register in all three banks to zero and deasserts `mem_req` and `busy`.
- R2: An accepted set-address operation writes the target address register with (address register `op_asel` + index register `op_isel`) mod 2^18. Both operands are the values held before that clock edge, so `op_dst` may equal `op_asel`.
- R3: Index register 0 always reads as zero. Direct writes to it have no effect.
- R4: An accepted operation with `op_dst` = 0 updates address register 0 and starts no memory access.
- R5: An accepted operation with `op_dst` in 1..5 raises `mem_req` with `mem_we` = 0 and `mem_addr` = the new sum on the next cycle. Data register `op_dst` keeps its old value until the edge at which `mem_ack` is seen, and then takes `mem_rdata`.
- R6: An accepted operation with `op_dst` of 6 or 7 raises `mem_req` with `mem_we` = 1, `mem_addr` = the new sum, and `mem_wdata` = data register `op_dst` as it was before the accepting edge. This holds even if that register is directly written on the same edge.
- R7: `busy` follows `mem_req`. `mem_req`, `mem_addr` and `mem_we` stay stable until the edge where `mem_ack` is high, and drop after it. An operation presented while `busy` is high is ignored.
- R8: The direct write port writes data register `wr_idx` with `wr_data` when `wr_bank` = 1, and writes index register `wr_idx` with `wr_data[17:0]` when `wr_bank` = 2. Other bank codes have no effect. When a load completes on the same edge as a direct write to the same data register, the load value is kept.
- R9: The read port returns, zero-extended to 60 bits, address register `rd_idx` for `rd_bank` = 0, data register `rd_idx` for 1, and index register `rd_idx` for 2. It returns zero for 3. The read is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Set-address operation present |
| op_dst | input | 3 | Target address register |
| op_asel | input | 3 | Source address register |
| op_isel | input | 3 | Source index register |
| busy | output | 1 | Memory access outstanding; operations ignored |
| wr_en | input | 1 | Direct write enable |
| wr_bank | input | 2 | Direct write bank: 1 data, 2 index |
| wr_idx | input | 3 | Direct write register number |
| wr_data | input | 60 | Direct write value |
| rd_bank | input | 2 | Read bank: 0 address, 1 data, 2 index, 3 none |
| rd_idx | input | 3 | Read register number |
| rd_data | output | 60 | Read value, zero-extended |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 store, 0 load |
| mem_addr | output | 18 | Memory word address |
| mem_wdata | output | 60 | Store data |
| mem_rdata | input | 60 | Load data, valid with `mem_ack` |
| mem_ack | input | 1 | Access complete |

## Verification
The contested cycles come in two kinds. In the first, a load completes while the direct port writes the same data register. The bench holds a direct write to that register for the whole outstanding load, so the completing edge always coincides with it, and it then expects the fetched word. In the second, a store is issued while its own data register is being overwritten. The bench drives both on one cycle and expects the older value on `mem_wdata` and the newer value in the register. A behavioural model, updated at every edge and compared on every cycle during a randomized phase with random memory latencies, also catches these collisions whenever they occur by chance.

// File: rtl/trf_pkg.sv
package trf_pkg;

    localparam int WORD_W    = 60;
    localparam int ADR_W     = 18;
    localparam int NREG      = 8;
    localparam int LOAD_LAST = 5;

    typedef enum logic [1:0] {
        BK_ADR  = 2'd0,
        BK_DAT  = 2'd1,
        BK_IDX  = 2'd2,
        BK_NONE = 2'd3
    } bank_e;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2
    } acc_e;

    // Register number of the written address register selects the side effect
    function automatic acc_e access_of(input int unsigned n);
        if (n == 0)
            return ACC_NONE;
        else if (n <= LOAD_LAST)
            return ACC_LOAD;
        else
            return ACC_STORE;
    endfunction

endpackage

// File: rtl/trf_banks.sv
module trf_banks
    import trf_pkg::*;
#(
    parameter int REG_N = NREG,
    parameter int DW    = WORD_W,
    parameter int AW    = ADR_W
) (
    input  logic                         clk,
    input  logic                         rst,
    // address bank write (set-address result)
    input  logic                         a_we,
    input  logic [$clog2(REG_N)-1:0]     a_idx,
    input  logic [AW-1:0]                a_data,
    // load completion into data bank
    input  logic                         ld_en,
    input  logic [$clog2(REG_N)-1:0]     ld_idx,
    input  logic [DW-1:0]                ld_data,
    // direct write port
    input  logic                         wr_en,
    input  logic [1:0]                   wr_bank,
    input  logic [$clog2(REG_N)-1:0]     wr_idx,
    input  logic [DW-1:0]                wr_data,
    // operand reads for the set-address path
    input  logic [$clog2(REG_N)-1:0]     a_rsel,
    output logic [AW-1:0]                a_rval,
    input  logic [$clog2(REG_N)-1:0]     b_rsel,
    output logic [AW-1:0]                b_rval,
    input  logic [$clog2(REG_N)-1:0]     x_rsel,
    output logic [DW-1:0]                x_rval,
    // external read port
    input  logic [1:0]                   rd_bank,
    input  logic [$clog2(REG_N)-1:0]     rd_idx,
    output logic [DW-1:0]                rd_data
);

    localparam int SW = $clog2(REG_N);

    logic [AW-1:0] a_q [REG_N];
    logic [DW-1:0] x_q [REG_N];
    logic [AW-1:0] b_q [REG_N];

    logic wr_dat, wr_ind;
    assign wr_dat = wr_en && (bank_e'(wr_bank) == BK_DAT);
    assign wr_ind = wr_en && (bank_e'(wr_bank) == BK_IDX);

    for (genvar i = 0; i < REG_N; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                a_q[i] <= '0;
            else if (a_we && a_idx == SW'(i))
                a_q[i] <= a_data;
        end

        // load completion has priority over a direct write
        always_ff @(posedge clk) begin
            if (rst)
                x_q[i] <= '0;
            else if (ld_en && ld_idx == SW'(i))
                x_q[i] <= ld_data;
            else if (wr_dat && wr_idx == SW'(i))
                x_q[i] <= wr_data;
        end

        if (i == 0) begin : g_zero
            always_ff @(posedge clk) b_q[i] <= '0;
        end else begin : g_live
            always_ff @(posedge clk) begin
                if (rst)
                    b_q[i] <= '0;
                else if (wr_ind && wr_idx == SW'(i))
                    b_q[i] <= wr_data[AW-1:0];
            end
        end
    end

    assign a_rval = a_q[a_rsel];
    assign b_rval = b_q[b_rsel];
    assign x_rval = x_q[x_rsel];

    always_comb begin
        case (bank_e'(rd_bank))
            BK_ADR:  rd_data = DW'(a_q[rd_idx]);
            BK_DAT:  rd_data = x_q[rd_idx];
            BK_IDX:  rd_data = DW'(b_q[rd_idx]);
            default: rd_data = '0;
        endcase
    end

    // R8: a completing load beats a same-register direct write
    p_load_beats_write_r8: assert property (@(posedge clk) disable iff (rst)
        (ld_en && wr_dat && ld_idx == wr_idx) |=> (x_q[$past(ld_idx)] == $past(ld_data)));

endmodule

// File: rtl/trf_addr_unit.sv
module trf_addr_unit
    import trf_pkg::*;
#(
    parameter int REG_N = NREG,
    parameter int AW    = ADR_W
) (
    input  logic [AW-1:0]            a_val,
    input  logic [AW-1:0]            b_val,
    input  logic [$clog2(REG_N)-1:0] dst,
    output logic [AW-1:0]            sum,
    output acc_e                     kind
);

    // modular sum: carry out of the top bit is dropped
    logic [AW:0] full;
    assign full = {1'b0, a_val} + {1'b0, b_val};
    assign sum  = full[AW-1:0];
    assign kind = access_of(int'(unsigned'(dst)));

endmodule

// File: rtl/trf_mem_seq.sv
module trf_mem_seq
    import trf_pkg::*;
#(
    parameter int REG_N = NREG,
    parameter int DW    = WORD_W,
    parameter int AW    = ADR_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     issue,
    input  acc_e                     kind,
    input  logic [$clog2(REG_N)-1:0] tgt,
    input  logic [AW-1:0]            addr,
    input  logic [DW-1:0]            sdata,
    output logic                     busy,
    output logic                     ld_done,
    output logic [$clog2(REG_N)-1:0] ld_idx,
    output logic [DW-1:0]            ld_data,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [AW-1:0]            mem_addr,
    output logic [DW-1:0]            mem_wdata,
    input  logic [DW-1:0]            mem_rdata,
    input  logic                     mem_ack
);

    localparam int SW = $clog2(REG_N);

    typedef struct packed {
        logic          valid;
        logic          store;
        logic [SW-1:0] tgt;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } cmd_t;

    cmd_t cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (cmd_q.valid) begin
            if (mem_ack)
                cmd_q.valid <= 1'b0;
        end else if (issue && kind != ACC_NONE) begin
            cmd_q.valid <= 1'b1;
            cmd_q.store <= (kind == ACC_STORE);
            cmd_q.tgt   <= tgt;
            cmd_q.addr  <= addr;
            cmd_q.data  <= (kind == ACC_STORE) ? sdata : '0;
        end
    end

    assign busy      = cmd_q.valid;
    assign mem_req   = cmd_q.valid;
    assign mem_we    = cmd_q.valid && cmd_q.store;
    assign mem_addr  = cmd_q.addr;
    assign mem_wdata = cmd_q.data;
    assign ld_done   = cmd_q.valid && !cmd_q.store && mem_ack;
    assign ld_idx    = cmd_q.tgt;
    assign ld_data   = mem_rdata;

    // R7: request and its attributes hold until acknowledged
    p_req_held_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R7: an acknowledged request retires on the next cycle
    p_ack_retires_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> !mem_req);

endmodule

// File: rtl/trig_regfile.sv
module trig_regfile
    import trf_pkg::*;
#(
    parameter int REG_N = NREG,
    parameter int DW    = WORD_W,
    parameter int AW    = ADR_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     op_valid,
    input  logic [$clog2(REG_N)-1:0] op_dst,
    input  logic [$clog2(REG_N)-1:0] op_asel,
    input  logic [$clog2(REG_N)-1:0] op_isel,
    output logic                     busy,
    input  logic                     wr_en,
    input  logic [1:0]               wr_bank,
    input  logic [$clog2(REG_N)-1:0] wr_idx,
    input  logic [DW-1:0]            wr_data,
    input  logic [1:0]               rd_bank,
    input  logic [$clog2(REG_N)-1:0] rd_idx,
    output logic [DW-1:0]            rd_data,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [AW-1:0]            mem_addr,
    output logic [DW-1:0]            mem_wdata,
    input  logic [DW-1:0]            mem_rdata,
    input  logic                     mem_ack
);

    localparam int SW = $clog2(REG_N);

    logic          accept;
    logic [AW-1:0] a_val, b_val, set_sum;
    logic [DW-1:0] x_sel_val;
    acc_e          kind;
    logic          ld_done;
    logic [SW-1:0] ld_idx;
    logic [DW-1:0] ld_data;

    assign accept = op_valid && !busy;

    trf_banks #(.REG_N(REG_N), .DW(DW), .AW(AW)) u_banks (
        .clk     (clk),
        .rst     (rst),
        .a_we    (accept),
        .a_idx   (op_dst),
        .a_data  (set_sum),
        .ld_en   (ld_done),
        .ld_idx  (ld_idx),
        .ld_data (ld_data),
        .wr_en   (wr_en),
        .wr_bank (wr_bank),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .a_rsel  (op_asel),
        .a_rval  (a_val),
        .b_rsel  (op_isel),
        .b_rval  (b_val),
        .x_rsel  (op_dst),
        .x_rval  (x_sel_val),
        .rd_bank (rd_bank),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    trf_addr_unit #(.REG_N(REG_N), .AW(AW)) u_addr (
        .a_val (a_val),
        .b_val (b_val),
        .dst   (op_dst),
        .sum   (set_sum),
        .kind  (kind)
    );

    trf_mem_seq #(.REG_N(REG_N), .DW(DW), .AW(AW)) u_mem (
        .clk       (clk),
        .rst       (rst),
        .issue     (accept),
        .kind      (kind),
        .tgt       (op_dst),
        .addr      (set_sum),
        .sdata     (x_sel_val),
        .busy      (busy),
        .ld_done   (ld_done),
        .ld_idx    (ld_idx),
        .ld_data   (ld_data),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack)
    );

    // R4: writing address register 0 starts no access
    p_a0_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (accept && op_dst == '0) |=> !mem_req);

    // R5: low numbers start a load at the computed address
    p_load_issue_r5: assert property (@(posedge clk) disable iff (rst)
        (accept && op_dst >= SW'(1) && op_dst <= SW'(LOAD_LAST))
        |=> (mem_req && !mem_we && mem_addr == $past(set_sum)));

    // R6: high numbers store the pre-edge data register
    p_store_issue_r6: assert property (@(posedge clk) disable iff (rst)
        (accept && op_dst > SW'(LOAD_LAST))
        |=> (mem_req && mem_we && mem_wdata == $past(x_sel_val)));

    // R3: index register 0 reads as zero
    p_b0_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_bank == 2'd2 && rd_idx == '0) |-> (rd_data == '0));

endmodule

// File: tb/trig_regfile_bench.sv
`timescale 1ns/1ps
module trig_regfile_bench;

    localparam real HALF = 4.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [2:0]  op_dst = '0, op_asel = '0, op_isel = '0;
    logic        busy;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_bank = '0;
    logic [2:0]  wr_idx = '0;
    logic [59:0] wr_data = '0;
    logic [1:0]  rd_bank = '0;
    logic [2:0]  rd_idx = '0;
    logic [59:0] rd_data;
    logic        mem_req, mem_we;
    logic [17:0] mem_addr;
    logic [59:0] mem_wdata;
    logic [59:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    int lat     = 3;
    int rcnt    = 0;
    int cyc_n   = 0;
    bit started = 0;
    bit done    = 0;

    always #(HALF) clk = ~clk;

    trig_regfile u_trig_regfile (
        .clk(clk), .rst(rst),
        .op_valid(op_valid), .op_dst(op_dst), .op_asel(op_asel), .op_isel(op_isel),
        .busy(busy),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_bank(rd_bank), .rd_idx(rd_idx), .rd_data(rd_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    function automatic logic [59:0] word_at(input logic [17:0] a);
        return {a, ~a, 24'hA5C3E1};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [59:0] act, input logic [59:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [17:0] mA [8];
    logic [59:0] mX [8];
    logic [17:0] mB [8];
    bit          m_pend, m_st;
    logic [2:0]  m_tgt;
    logic [17:0] m_addr;
    logic [59:0] m_data;

    always @(posedge clk) begin
        bit          take, retire;
        logic [17:0] s;
        logic [59:0] sd;
        if (rst) begin
            for (int i = 0; i < 8; i++) begin
                mA[i] = '0; mX[i] = '0; mB[i] = '0;
            end
            m_pend = 0; m_st = 0; m_tgt = '0; m_addr = '0; m_data = '0;
            started = 1;
        end else begin
            take   = op_valid && !m_pend;
            retire = m_pend && mem_ack;
            s      = mA[op_asel] + mB[op_isel];
            sd     = mX[op_dst];
            if (wr_en && wr_bank == 2'd1) mX[wr_idx] = wr_data;
            if (wr_en && wr_bank == 2'd2 && wr_idx != 3'd0) mB[wr_idx] = wr_data[17:0];
            if (retire && !m_st) mX[m_tgt] = mem_rdata;
            if (retire) m_pend = 0;
            if (take) begin
                mA[op_dst] = s;
                if (op_dst != 3'd0) begin
                    m_pend = 1;
                    m_st   = (op_dst >= 3'd6);
                    m_tgt  = op_dst;
                    m_addr = s;
                    m_data = sd;
                end
            end
        end
    end

    function automatic logic [59:0] model_read(input logic [1:0] bk, input logic [2:0] ix);
        case (bk)
            2'd0:    return {42'd0, mA[ix]};
            2'd1:    return mX[ix];
            2'd2:    return {42'd0, mB[ix]};
            default: return '0;
        endcase
    endfunction

    // per-cycle comparison, 2 ns after the falling edge
    always begin
        @(negedge clk);
        #2;
        if (started && !rst && !done) begin
            chk(busy == m_pend, "R7 busy", {59'd0, busy}, {59'd0, m_pend});
            chk(mem_req == m_pend, "R5 R6 mem_req", {59'd0, mem_req}, {59'd0, m_pend});
            if (m_pend) begin
                chk(mem_addr == m_addr, "R2 mem_addr", {42'd0, mem_addr}, {42'd0, m_addr});
                chk(mem_we == m_st, "R6 mem_we", {59'd0, mem_we}, {59'd0, m_st});
                if (m_st)
                    chk(mem_wdata == m_data, "R6 mem_wdata", mem_wdata, m_data);
            end
            chk(rd_data == model_read(rd_bank, rd_idx), "R9 rd_data", rd_data, model_read(rd_bank, rd_idx));
        end
    end

    // memory responder
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
            rcnt    = 0;
        end else if (mem_req) begin
            if (rcnt >= lat) begin
                mem_ack   = 1'b1;
                mem_rdata = word_at(mem_addr);
            end else begin
                rcnt++;
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc_n++;
        if (cyc_n > 60000 && !done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc_n, 60000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic do_op(input logic [2:0] d, input logic [2:0] a, input logic [2:0] b);
        @(negedge clk);
        op_valid = 1'b1; op_dst = d; op_asel = a; op_isel = b;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic dwrite(input logic [1:0] bk, input logic [2:0] ix, input logic [59:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_bank = bk; wr_idx = ix; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] bk, input logic [2:0] ix, input logic [59:0] exp, input string tag);
        @(negedge clk);
        rd_bank = bk; rd_idx = ix;
        #2;
        chk(rd_data == exp, tag, rd_data, exp);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        peek(2'd0, 3'd5, 60'd0, "R1 A5 after reset");
        peek(2'd1, 3'd7, 60'd0, "R1 X7 after reset");
        chk(!mem_req && !busy, "R1 idle after reset", {59'd0, mem_req}, 60'd0);

        // direct writes (R8) and index 0 (R3)
        dwrite(2'd2, 3'd1, 60'd100);
        dwrite(2'd2, 3'd2, 60'h3FFFF);
        dwrite(2'd2, 3'd0, 60'd7);
        peek(2'd2, 3'd0, 60'd0, "R3 B0 ignores write");
        peek(2'd2, 3'd1, 60'd100, "R8 B1 direct write");
        dwrite(2'd0, 3'd4, 60'd55);
        peek(2'd0, 3'd4, 60'd0, "R8 bank code 0 ignored");
        dwrite(2'd1, 3'd6, 60'hAAA);

        // R4: A0 <- A0 + B1
        do_op(3'd0, 3'd0, 3'd1);
        #2;
        chk(!mem_req, "R4 no request for A0", {59'd0, mem_req}, 60'd0);
        peek(2'd0, 3'd0, 60'd100, "R4 A0 updated");

        // R5: A1 <- A0 + B1 = 200, load with latency 4
        lat = 4;
        do_op(3'd1, 3'd0, 3'd1);
        #2;
        chk(mem_req && !mem_we && mem_addr == 18'd200, "R5 load request", {42'd0, mem_addr}, 60'd200);
        peek(2'd1, 3'd1, 60'd0, "R5 X1 old before ack");
        // R7: op ignored while busy
        do_op(3'd2, 3'd0, 3'd1);
        wait_idle();
        peek(2'd1, 3'd1, word_at(18'd200), "R5 X1 loaded");
        peek(2'd0, 3'd2, 60'd0, "R7 op while busy ignored");

        // R2: wrap 100 + 0x3FFFF into A0 (A0 target: no access)
        do_op(3'd0, 3'd0, 3'd2);
        peek(2'd0, 3'd0, 60'd99, "R2 sum wraps");
        // R2: self-referencing A1 <- A1 + B1 = 300
        lat = 0;
        do_op(3'd1, 3'd1, 3'd1);
        #2;
        chk(mem_addr == 18'd300, "R2 pre-write operand", {42'd0, mem_addr}, 60'd300);
        wait_idle();
        peek(2'd0, 3'd1, 60'd300, "R2 A1 self update");

        // R6: store X6 while X6 is rewritten on the issuing cycle
        lat = 3;
        @(negedge clk);
        op_valid = 1'b1; op_dst = 3'd6; op_asel = 3'd0; op_isel = 3'd1;
        wr_en = 1'b1; wr_bank = 2'd1; wr_idx = 3'd6; wr_data = 60'hBBB;
        @(negedge clk);
        op_valid = 1'b0; wr_en = 1'b0;
        #2;
        chk(mem_req && mem_we && mem_wdata == 60'hAAA, "R6 store old data", mem_wdata, 60'hAAA);
        chk(mem_addr == 18'd199, "R6 store address", {42'd0, mem_addr}, 60'd199);
        wait_idle();
        peek(2'd1, 3'd6, 60'hBBB, "R6 X6 took direct write");

        // R8: load completion collides with direct write to same register
        lat = 2;
        @(negedge clk);
        wr_en = 1'b1; wr_bank = 2'd1; wr_idx = 3'd3; wr_data = 60'h123;
        do_op(3'd3, 3'd1, 3'd0);
        wait_idle();
        wr_en = 1'b0;
        peek(2'd1, 3'd3, word_at(18'd300), "R8 load beats write");
        peek(2'd3, 3'd3, 60'd0, "R9 bank 3 reads zero");

        // randomized phase
        for (int k = 0; k < 1500; k++) begin
            @(negedge clk);
            op_valid = ($urandom % 3) == 0;
            op_dst   = 3'($urandom);
            op_asel  = 3'($urandom);
            op_isel  = 3'($urandom);
            wr_en    = ($urandom % 3) == 0;
            wr_bank  = 2'($urandom);
            wr_idx   = 3'($urandom);
            wr_data  = {28'($urandom), 32'($urandom)};
            rd_bank  = 2'($urandom);
            rd_idx   = 3'($urandom);
            if (!mem_req) lat = $urandom % 4;
        end
        @(negedge clk);
        op_valid = 1'b0; wr_en = 1'b0;
        wait_idle();

        // R1: reset mid-run clears state
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        peek(2'd1, 3'd6, 60'd0, "R1 X6 cleared");
        peek(2'd2, 3'd2, 60'd0, "R1 B2 cleared");
        chk(!mem_req, "R1 no request after reset", {59'd0, mem_req}, 60'd0);

        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule